// File: doc/BRIEF.md
# Serial Transmit Buffer with Line Status

This block is the transmit half of an asynchronous serial port. A processor writes a byte into a one-deep holding register. When the shift register is idle, the byte moves into it and goes out on a single line. Each frame is a start bit, eight data bits and a stop bit. A 16-bit divisor sets the bit time: every bit lasts sixteen times the divisor in clocks.

Two status flags describe the buffer. One flag means the holding stage is free. The other means both the holding stage and the shifter are empty. All other bits of the 8-bit status byte read zero.

An interrupt request signals that the holding stage is free again. The request is gated by an enable input. It is cleared by a new write or by an acknowledge pulse, which stands for the processor reading the interrupt cause.

Top module: `uart_tx_path`

## Requirements
- R1: After reset the serial output is 1, the status byte reads 0x60, and the transmit-empty interrupt is pending. The pending interrupt is visible on `irq` as soon as `irq_en` is 1.
- R2: Status bit 5 is 1 when the holding register is empty. It is 0 from the clock edge that captures a write until the byte has moved into the shifter.
- R3: Status bit 6 is 1 only when the holding register is empty and no frame is being shifted out.
- R4: Status bits 7 and 0 to 4 always read 0.
- R5: A frame is a start bit of 0, then the 8 data bits with the least significant bit first, then a stop bit of 1. The line rests at 1 between frames.
- R6: Every bit lasts exactly 16 × divisor clocks, for any divisor from 1 to 65535. A divisor of 0 behaves as 1.
- R7: When the shifter is idle, a byte written at clock edge W moves into the shifter at edge W+1. At that edge the start bit appears on the line and status bit 5 returns to 1.
- R8: If the holding register is full when a frame ends, the held byte moves into the shifter one clock after the end of the stop bit. The line is 1 for that one clock.
- R9: A write while the holding register is full replaces the held byte. The replaced byte is never sent.
- R10: `irq` equals `irq_en` AND the pending flag. The pending flag is set at reset and at each move of a byte into the shifter.
- R11: A write clears the pending flag. An `irq_ack` pulse also clears it, unless a move into the shifter happens at the same edge. `irq_ack` has no effect on the status byte or the serial line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Bit-rate divisor (bit time = 16 × divisor clocks) |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| irq_en | input | 1 | Transmit-empty interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse (cause read) |
| txd | output | 1 | Serial output |
| line_status | output | 8 | Status byte: bit 5 holding empty, bit 6 all empty |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
The timing is fixed relative to the write edge W:
- The status flags change at W.
- The byte moves into the shifter at W+1.
- Each bit then spans edges W+1+16·d·i through W+16·d·(i+1), where d is the divisor.
- The line is idle again, with the status byte at 0x60, after edge W+1+160·d.
- A queued byte starts one clock after that.

The bench drives its inputs and samples the outputs on falling edges. It checks every bit of the line in its first and its last clock, so a bit time that is off by a single cycle shows up. It sweeps several divisors, including 0, over several byte patterns, as well as back-to-back and overwrite sequences.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int STAT_W    = 8;
  localparam int STAT_HOLD = 5;
  localparam int STAT_ALL  = 6;
endpackage

// File: rtl/txp_baud.sv
module txp_baud #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             bit_done
);
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [DIV_W-1:0] pre_q, pre_d, eff_div;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             tick;

  assign eff_div  = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick     = (pre_q == eff_div - DIV_W'(1));
  assign bit_done = tick && (sub_q == SUB_LAST);

  always_comb begin
    pre_d = pre_q;
    sub_d = sub_q;
    if (restart) begin
      pre_d = '0;
      sub_d = '0;
    end else if (tick) begin
      pre_d = '0;
      sub_d = (sub_q == SUB_LAST) ? '0 : sub_q + SUB_W'(1);
    end else begin
      pre_d = pre_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sub_q <= '0;
    end else begin
      pre_q <= pre_d;
      sub_q <= sub_d;
    end
  end

  // R6
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !bit_done || (eff_div == DIV_W'(1) && OVS == 1));
endmodule

// File: rtl/txp_shifter.sv
module txp_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              bit_done,
  output logic              busy,
  output logic              txd
);
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam logic [IDX_W-1:0] IDX_STOP = IDX_W'(DATA_W + 1);

  logic [DATA_W:0]  sh_q, sh_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    if (load) begin
      sh_d   = {load_data, 1'b0};
      idx_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q && bit_done) begin
      if (idx_q == IDX_STOP) begin
        busy_d = 1'b0;
      end else begin
        sh_d  = {1'b1, sh_q[DATA_W:1]};
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign txd  = busy_q ? sh_q[0] : 1'b1;

  // R5
  stop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txd));
  // R7
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy && !txd);
endmodule

// File: rtl/txp_hold.sv
module txp_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_en,
  input  logic              irq_ack,
  input  logic              shifter_busy,
  output logic              load,
  output logic [DATA_W-1:0] load_data,
  output logic              hold_empty,
  output logic              irq
);
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              full_q, full_d;
  logic              pend_q, pend_d;

  assign load = full_q && !shifter_busy;

  always_comb begin
    hold_d = wr_en ? wr_data : hold_q;
    full_d = wr_en ? 1'b1 : (load ? 1'b0 : full_q);
    if (wr_en)        pend_d = 1'b0;
    else if (load)    pend_d = 1'b1;
    else if (irq_ack) pend_d = 1'b0;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      pend_q <= 1'b1;
    end else begin
      hold_q <= hold_d;
      full_q <= full_d;
      pend_q <= pend_d;
    end
  end

  assign load_data  = hold_q;
  assign hold_empty = !full_q;
  assign irq        = pend_q && irq_en;

  // R2
  write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_empty);
  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
  // R11
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !load && !wr_en) |=> !irq);
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_en,
  input  logic              irq_ack,
  output logic              txd,
  output logic [STAT_W-1:0] line_status,
  output logic              irq
);
  logic              load, busy, bit_done, hold_empty, all_empty;
  logic [DATA_W-1:0] load_data;

  txp_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .irq_en(irq_en), .irq_ack(irq_ack), .shifter_busy(busy),
    .load(load), .load_data(load_data), .hold_empty(hold_empty), .irq(irq)
  );

  txp_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk(clk), .rst_n(rst_n), .restart(load), .divisor(divisor),
    .bit_done(bit_done)
  );

  txp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
    .bit_done(bit_done), .busy(busy), .txd(txd)
  );

  assign all_empty = hold_empty && !busy;

  always_comb begin
    line_status            = '0;
    line_status[STAT_HOLD] = hold_empty;
    line_status[STAT_ALL]  = all_empty;
  end

  // R3
  all_implies_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_status[STAT_ALL] |-> line_status[STAT_HOLD]);
  // R8
  idle_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> txd);
endmodule

// File: tb/uart_tx_path_test.sv
module uart_tx_path_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        irq_en = 1'b0;
  logic        irq_ack = 1'b0;
  logic        txd, irq;
  logic [7:0]  line_status;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  uart_tx_path uut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .wr_en(wr_en),
    .wr_data(wr_data), .irq_en(irq_en), .irq_ack(irq_ack),
    .txd(txd), .line_status(line_status), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Writes one byte; returns at the falling edge after the capture edge W.
  task automatic put(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Called at the falling edge after the load edge L. Checks all ten bits in
  // their first and last clock and returns at L+160d (+half cycle).
  // nwr extra writes are issued in the first cycles of the start bit.
  task automatic frame(input int d, input logic [7:0] b, input int nwr,
                       input logic [7:0] b1, input logic [7:0] b2);
    for (int i = 0; i < 10; i++) begin
      automatic logic e = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
      automatic int n = 16*d - 1;
      if (i == 0 && nwr > 0) begin wr_en = 1'b1; wr_data = b1; end
      chk((i == 0) ? "R5 start bit first clock" : "R5 R6 bit first clock", {7'd0, txd}, {7'd0, e});
      if (i == 0 && nwr > 0) begin
        @(negedge clk); n--;
        if (nwr > 1) begin wr_data = b2; @(negedge clk); n--; end
        wr_en = 1'b0;
      end
      repeat (n) @(negedge clk);
      chk("R6 bit last clock", {7'd0, txd}, {7'd0, e});
      @(negedge clk);
    end
  endtask

  task automatic single(input logic [15:0] dv, input logic [7:0] b, input logic en);
    automatic int d = (dv == 0) ? 1 : int'(dv);
    divisor = dv; irq_en = en;
    put(b);
    chk("R2 R3 status after write", line_status, 8'h00);
    chk("R11 irq cleared by write", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R7 status after load", line_status, 8'h20);
    chk("R10 irq after load", {7'd0, irq}, {7'd0, en});
    frame(d, b, 0, 8'h00, 8'h00);
    chk("R3 R4 idle status", line_status, 8'h60);
    chk("R5 idle line", {7'd0, txd}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset line", {7'd0, txd}, 8'h01);
    chk("R1 R4 reset status", line_status, 8'h60);
    chk("R10 irq masked", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    irq_en = 1'b1;
    #1;
    chk("R1 R10 pending after reset", {7'd0, irq}, 8'h01);
    irq_en = 1'b0;
    @(negedge clk);

    // Sweep divisors and byte patterns.
    for (int dv = 0; dv < 4; dv++) begin
      single(16'(dv), 8'hA5, 1'b1);
      single(16'(dv), 8'h01, 1'b0);
      single(16'(dv), 8'hFE, 1'b1);
      single(16'(dv), 8'(8'h3C + dv), 1'b1);
    end
    single(16'd5, 8'h80, 1'b1);

    // Back-to-back: R8.
    divisor = 16'd2; irq_en = 1'b1;
    put(8'h5A);
    @(negedge clk);
    frame(2, 8'h5A, 1, 8'hC3, 8'h00);
    chk("R8 gap status", line_status, 8'h00);
    chk("R8 gap line", {7'd0, txd}, 8'h01);
    @(negedge clk);
    chk("R8 second load status", line_status, 8'h20);
    frame(2, 8'hC3, 0, 8'h00, 8'h00);
    chk("R8 idle after pair", line_status, 8'h60);

    // Overwrite: R9. B is replaced by C.
    divisor = 16'd1;
    put(8'h11);
    @(negedge clk);
    frame(1, 8'h11, 2, 8'h22, 8'h96);
    @(negedge clk);
    chk("R9 overwrite status", line_status, 8'h20);
    frame(1, 8'h96, 0, 8'h00, 8'h00);
    chk("R9 idle", line_status, 8'h60);

    // Acknowledge: R11.
    irq_en = 1'b1;
    #1;
    chk("R10 irq pending while idle", {7'd0, irq}, 8'h01);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R11 ack clears irq", {7'd0, irq}, 8'h00);
    chk("R11 ack keeps status", line_status, 8'h60);
    chk("R11 ack keeps line", {7'd0, txd}, 8'h01);
    irq_en = 1'b0; @(negedge clk); irq_en = 1'b1; #1;
    chk("R11 stays cleared after enable toggle", {7'd0, irq}, 8'h00);
    single(16'd1, 8'h6B, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule